// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the register bank of a DMA controller with up to 64 channels. For each channel it keeps five state bits: request enable, error-interrupt enable, interrupt pending, error pending and done. Each 64-bit vector is read as two 32-bit words, one for the upper channels and one for the lower channels.

Software changes a single channel by writing that channel's number to a byte-wide command port. This avoids a read-modify-write and the race that comes with it. Pending interrupt and error words can also be cleared in bulk by writing ones to them.

The channel engines report completions and errors on event inputs. The first error report is latched into a status word that holds a channel field and cause fields. The bank drives:
- the request-enable vector,
- one-cycle start pulses,
- the arbitration and clock-gating control bits,
- a combined interrupt line.

Top module: `dmacsr_bank`

Word address map (`bus_addr`, word index):

| Index | Name | Access |
|-------|------|--------|
| 0 | control | read/write |
| 1 | error status | read-only |
| 2 | request enable, ch 63..32 | read-only |
| 3 | request enable, ch 31..0 | read-only |
| 4 | error-interrupt enable, ch 63..32 | read-only |
| 5 | error-interrupt enable, ch 31..0 | read-only |
| 6 | interrupt pending, ch 63..32 | write-one-to-clear |
| 7 | interrupt pending, ch 31..0 | write-one-to-clear |
| 8 | error pending, ch 63..32 | write-one-to-clear |
| 9 | error pending, ch 31..0 | write-one-to-clear |
| 10 | done, ch 63..32 | read-only |
| 11 | done, ch 31..0 | read-only |

Command ports, each taking a channel number in `bus_wdata[7:0]`:

| Index | Command |
|-------|---------|
| 16 | set request enable |
| 17 | clear request enable |
| 18 | set error-interrupt enable |
| 19 | clear error-interrupt enable |
| 20 | clear interrupt pending |
| 21 | clear error pending |
| 22 | start |
| 23 | clear done |

## Requirements
- R1: After reset, every per-channel bit, the control word and the error status word read zero, and `irq`, `req_en` and `start_req` are low.
- R2: A write of channel n to the set-request port sets only bit n of `req_en`, and a write to the clear-request port clears only bit n. Channels 63..32 read at word 2 (channel 32 at bit 0) and channels 31..0 read at word 3.
- R3: The set and clear error-interrupt-enable ports change only the numbered channel's enable. The enables read back at words 4 and 5.
- R4: A write of channel n to the start port raises `start_req[n]` alone, for exactly the one cycle after the write.
- R5: A command value of 64 or more (bit 6 or bit 7 set) changes no state and produces no start pulse.
- R6: A completion event on channel n sets its done bit and its interrupt-pending bit. The clear-done port clears only the done bit, and the clear-interrupt port clears only the pending bit.
- R7: Writing to an interrupt-pending or error-pending word clears exactly the bits written as one. Writing all ones clears the whole half.
- R8: An error event on channel n sets its error-pending bit (words 8 and 9).
- R9: With the status invalid, an error event is captured in word 1 with this layout:
  - bit 31: valid
  - bit 15: group priority error
  - bit 14: channel priority error
  - bits 13:8: channel number
  - bits 7..0: cause bits in this order, from bit 7 down — source address, source offset, destination address, destination offset, count configuration, scatter/gather configuration, source bus, destination bus.
- R10: While the status is valid, later error events leave it unchanged. It returns to zero when software clears the error-pending bit of the recorded channel, by port or by word.
- R11: In the control word only bit 31 (`dyn_clk_en`), bit 3 (`rr_group`) and bit 2 (`rr_chan`) are stored and exported. All other bits read zero.
- R12: `irq` is high in the cycle after any interrupt-pending bit is set, or any error-pending bit whose error-interrupt enable is set. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid the following cycle |
| bus_addr | input | 5 | Word index of the register |
| bus_wdata | input | 32 | Write data; command ports use bits 7:0 |
| bus_rdata | output | 32 | Registered read data |
| done_vld | input | 1 | Completion event from a channel engine |
| done_chan | input | 6 | Channel of the completion event |
| err_vld | input | 1 | Error event from a channel engine |
| err_chan | input | 6 | Channel of the error event |
| err_cause | input | 10 | Bit 9 group priority, bit 8 channel priority, bits 7:0 causes in R9 order |
| req_en | output | NUM_CH | Request-enable vector |
| start_req | output | NUM_CH | One-cycle start pulses |
| dyn_clk_en | output | 1 | Dynamic clock enable |
| rr_group | output | 1 | Round-robin group arbitration |
| rr_chan | output | 1 | Round-robin channel arbitration |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that bus writes and reads are single-cycle strobes and that event channel numbers are in range. They also assume that an event and a software clear of the same bit in the same cycle resolve in favour of the event. The stimulus drives every strobe for one cycle from the falling edge and never issues an event and a clear for the same channel together. Out-of-range values go only to the command ports, where R5 makes them harmless.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;
   localparam int CHN_W  = 6;
   localparam int WORD_W = 32;
   localparam int ADDR_W = 5;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL   = 5'd0,
      A_ESTAT  = 5'd1,
      A_RQE_H  = 5'd2,
      A_RQE_L  = 5'd3,
      A_EIE_H  = 5'd4,
      A_EIE_L  = 5'd5,
      A_INP_H  = 5'd6,
      A_INP_L  = 5'd7,
      A_ERP_H  = 5'd8,
      A_ERP_L  = 5'd9,
      A_DNE_H  = 5'd10,
      A_DNE_L  = 5'd11,
      A_C_SRQ  = 5'd16,
      A_C_CRQ  = 5'd17,
      A_C_SEI  = 5'd18,
      A_C_CEI  = 5'd19,
      A_C_CIN  = 5'd20,
      A_C_CER  = 5'd21,
      A_C_STA  = 5'd22,
      A_C_CDN  = 5'd23
   } csr_addr_e;

   localparam int CTRL_DYN = 31;
   localparam int CTRL_RRG = 3;
   localparam int CTRL_RRC = 2;
endpackage

// File: rtl/dmacsr_cmd_decode.sv
module dmacsr_cmd_decode
   import dmacsr_pkg::*;
#(
   parameter int NUM_CH = 64
) (
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [NUM_CH-1:0] set_rq,
   output logic [NUM_CH-1:0] clr_rq,
   output logic [NUM_CH-1:0] set_ei,
   output logic [NUM_CH-1:0] clr_ei,
   output logic [NUM_CH-1:0] clr_in,
   output logic [NUM_CH-1:0] clr_er,
   output logic [NUM_CH-1:0] go,
   output logic [NUM_CH-1:0] clr_dn
);
   localparam logic [7:0] NCH8 = 8'(NUM_CH);

   logic              chan_ok;
   logic [NUM_CH-1:0] hit;
   logic [NUM_CH-1:0] w1c_in;
   logic [NUM_CH-1:0] w1c_er;

   assign chan_ok = bus_wdata[7:0] < NCH8;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
      localparam csr_addr_e IN_WORD = (i >= 32) ? A_INP_H : A_INP_L;
      localparam csr_addr_e ER_WORD = (i >= 32) ? A_ERP_H : A_ERP_L;
      assign hit[i]    = chan_ok && (bus_wdata[CHN_W-1:0] == 6'(i));
      assign w1c_in[i] = bus_wr && (bus_addr == IN_WORD) && bus_wdata[i % 32];
      assign w1c_er[i] = bus_wr && (bus_addr == ER_WORD) && bus_wdata[i % 32];
   end

   always_comb begin
      set_rq = (bus_wr && bus_addr == A_C_SRQ) ? hit : '0;
      clr_rq = (bus_wr && bus_addr == A_C_CRQ) ? hit : '0;
      set_ei = (bus_wr && bus_addr == A_C_SEI) ? hit : '0;
      clr_ei = (bus_wr && bus_addr == A_C_CEI) ? hit : '0;
      go     = (bus_wr && bus_addr == A_C_STA) ? hit : '0;
      clr_dn = (bus_wr && bus_addr == A_C_CDN) ? hit : '0;
      clr_in = ((bus_wr && bus_addr == A_C_CIN) ? hit : '0) | w1c_in;
      clr_er = ((bus_wr && bus_addr == A_C_CER) ? hit : '0) | w1c_er;
   end
endmodule

// File: rtl/dmacsr_chan_bits.sv
module dmacsr_chan_bits #(
   parameter int NUM_CH = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_rq,
   input  logic [NUM_CH-1:0] clr_rq,
   input  logic [NUM_CH-1:0] set_ei,
   input  logic [NUM_CH-1:0] clr_ei,
   input  logic [NUM_CH-1:0] clr_in,
   input  logic [NUM_CH-1:0] clr_er,
   input  logic [NUM_CH-1:0] clr_dn,
   input  logic [NUM_CH-1:0] done_hit,
   input  logic [NUM_CH-1:0] err_hit,
   output logic [NUM_CH-1:0] rqe,
   output logic [NUM_CH-1:0] eie,
   output logic [NUM_CH-1:0] inp,
   output logic [NUM_CH-1:0] erp,
   output logic [NUM_CH-1:0] dne
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rqe[i] <= 1'b0;
            eie[i] <= 1'b0;
            inp[i] <= 1'b0;
            erp[i] <= 1'b0;
            dne[i] <= 1'b0;
         end else begin
            if (set_rq[i])      rqe[i] <= 1'b1;
            else if (clr_rq[i]) rqe[i] <= 1'b0;
            if (set_ei[i])      eie[i] <= 1'b1;
            else if (clr_ei[i]) eie[i] <= 1'b0;
            if (done_hit[i])    inp[i] <= 1'b1;
            else if (clr_in[i]) inp[i] <= 1'b0;
            if (err_hit[i])     erp[i] <= 1'b1;
            else if (clr_er[i]) erp[i] <= 1'b0;
            if (done_hit[i])    dne[i] <= 1'b1;
            else if (clr_dn[i]) dne[i] <= 1'b0;
         end
      end

      assert_done_sets_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
         done_hit[i] |=> (inp[i] && dne[i]));
      assert_err_sets_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
         err_hit[i] |=> erp[i]);
   end
endmodule

// File: rtl/dmacsr_err_capture.sv
module dmacsr_err_capture
   import dmacsr_pkg::*;
#(
   parameter int NUM_CH = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              err_ok,
   input  logic [CHN_W-1:0]  err_chan,
   input  logic [9:0]        err_cause,
   input  logic [NUM_CH-1:0] sw_clr_er,
   output logic [WORD_W-1:0] estat
);
   logic             vld_q;
   logic [CHN_W-1:0] chan_q;
   logic [9:0]       cause_q;
   logic             release_now;

   assign release_now = vld_q && sw_clr_er[chan_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         chan_q  <= '0;
         cause_q <= '0;
      end else if (err_ok && (!vld_q || release_now)) begin
         vld_q   <= 1'b1;
         chan_q  <= err_chan;
         cause_q <= err_cause;
      end else if (release_now) begin
         vld_q   <= 1'b0;
         chan_q  <= '0;
         cause_q <= '0;
      end
   end

   assign estat = {vld_q, 15'd0, cause_q[9:8], chan_q, cause_q[7:0]};

   assert_capture_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ok && !vld_q) |=> (estat[31] && estat[13:8] == $past(err_chan)));
   assert_hold_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && !release_now) |=> $stable(estat));
endmodule

// File: rtl/dmacsr_bank.sv
module dmacsr_bank
   import dmacsr_pkg::*;
#(
   parameter int NUM_CH = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [4:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              done_vld,
   input  logic [5:0]        done_chan,
   input  logic              err_vld,
   input  logic [5:0]        err_chan,
   input  logic [9:0]        err_cause,
   output logic [NUM_CH-1:0] req_en,
   output logic [NUM_CH-1:0] start_req,
   output logic              dyn_clk_en,
   output logic              rr_group,
   output logic              rr_chan,
   output logic              irq
);
   localparam logic [7:0] NCH8 = 8'(NUM_CH);

   initial begin
      if (NUM_CH < 2 || NUM_CH > 64)
         $error("dmacsr_bank: NUM_CH must lie in 2..64");
   end

   logic [NUM_CH-1:0] set_rq, clr_rq, set_ei, clr_ei, clr_in, clr_er, go, clr_dn;
   logic [NUM_CH-1:0] done_hit, err_hit;
   logic [NUM_CH-1:0] rqe, eie, inp, erp, dne;
   logic [31:0]       estat;
   logic [31:0]       ctrl_q;
   logic              err_ok;

   dmacsr_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .set_rq(set_rq), .clr_rq(clr_rq), .set_ei(set_ei), .clr_ei(clr_ei),
      .clr_in(clr_in), .clr_er(clr_er), .go(go), .clr_dn(clr_dn)
   );

   assign err_ok = err_vld && ({2'b00, err_chan} < NCH8);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_evt
      assign done_hit[i] = done_vld && (done_chan == 6'(i));
      assign err_hit[i]  = err_vld && (err_chan == 6'(i));
   end

   dmacsr_chan_bits #(.NUM_CH(NUM_CH)) u_bits (
      .clk(clk), .rst_n(rst_n),
      .set_rq(set_rq), .clr_rq(clr_rq), .set_ei(set_ei), .clr_ei(clr_ei),
      .clr_in(clr_in), .clr_er(clr_er), .clr_dn(clr_dn),
      .done_hit(done_hit), .err_hit(err_hit),
      .rqe(rqe), .eie(eie), .inp(inp), .erp(erp), .dne(dne)
   );

   dmacsr_err_capture #(.NUM_CH(NUM_CH)) u_ecap (
      .clk(clk), .rst_n(rst_n), .err_ok(err_ok), .err_chan(err_chan),
      .err_cause(err_cause), .sw_clr_er(clr_er), .estat(estat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         start_req <= '0;
      end else begin
         start_req <= go;
         if (bus_wr && bus_addr == A_CTRL) begin
            ctrl_q <= '0;
            ctrl_q[CTRL_DYN] <= bus_wdata[CTRL_DYN];
            ctrl_q[CTRL_RRG] <= bus_wdata[CTRL_RRG];
            ctrl_q[CTRL_RRC] <= bus_wdata[CTRL_RRC];
         end
      end
   end

   assign dyn_clk_en = ctrl_q[CTRL_DYN];
   assign rr_group   = ctrl_q[CTRL_RRG];
   assign rr_chan    = ctrl_q[CTRL_RRC];
   assign req_en     = rqe;
   assign irq        = |(inp | (erp & eie));

   logic [63:0] rqe64, eie64, inp64, erp64, dne64;
   assign rqe64 = 64'(rqe);
   assign eie64 = 64'(eie);
   assign inp64 = 64'(inp);
   assign erp64 = 64'(erp);
   assign dne64 = 64'(dne);

   logic [31:0] rd_mux;
   always_comb begin
      case (bus_addr)
         A_CTRL:  rd_mux = ctrl_q;
         A_ESTAT: rd_mux = estat;
         A_RQE_H: rd_mux = rqe64[63:32];
         A_RQE_L: rd_mux = rqe64[31:0];
         A_EIE_H: rd_mux = eie64[63:32];
         A_EIE_L: rd_mux = eie64[31:0];
         A_INP_H: rd_mux = inp64[63:32];
         A_INP_L: rd_mux = inp64[31:0];
         A_ERP_H: rd_mux = erp64[63:32];
         A_ERP_L: rd_mux = erp64[31:0];
         A_DNE_H: rd_mux = dne64[63:32];
         A_DNE_L: rd_mux = dne64[31:0];
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   assert_start_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(start_req));
   assert_bad_chan_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_C_STA && bus_wdata[7:0] >= NCH8) |=> (start_req == '0));
   assert_irq_on_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (done_vld && ({2'b00, done_chan} < NCH8)) |=> irq);
endmodule

// File: tb/dmacsr_bank_bench.sv
module dmacsr_bank_bench;
   import dmacsr_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        done_vld = 1'b0, err_vld = 1'b0;
   logic [5:0]  done_chan = '0, err_chan = '0;
   logic [9:0]  err_cause = '0;
   logic [63:0] req_en, start_req;
   logic        dyn_clk_en, rr_group, rr_chan, irq;

   always #4 clk = ~clk;

   dmacsr_bank #(.NUM_CH(64)) u_dmacsr_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .done_vld(done_vld), .done_chan(done_chan), .err_vld(err_vld),
      .err_chan(err_chan), .err_cause(err_cause), .req_en(req_en),
      .start_req(start_req), .dyn_clk_en(dyn_clk_en), .rr_group(rr_group),
      .rr_chan(rr_chan), .irq(irq)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   always @(posedge clk) rd_seen <= bus_rd;

   always @(negedge clk) begin
      if (rd_seen) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_chk++;
         if (bus_rdata !== e) begin
            n_fail++;
            $display("FAIL %s: read 0x%08h expected 0x%08h", t, bus_rdata, e);
         end
      end
   end

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string t);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", t, act, exp);
      end
   endtask

   task automatic wr(input csr_addr_e a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input csr_addr_e a, input logic [31:0] e, input string t);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic done_ev(input logic [5:0] c);
      @(negedge clk);
      done_vld = 1'b1; done_chan = c;
      @(negedge clk);
      done_vld = 1'b0;
   endtask

   task automatic err_ev(input logic [5:0] c, input logic [9:0] cause);
      @(negedge clk);
      err_vld = 1'b1; err_chan = c; err_cause = cause;
      @(negedge clk);
      err_vld = 1'b0;
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk({63'd0, irq}, 64'd0, "R1 irq");
      chk(req_en, 64'd0, "R1 req_en");
      chk(start_req, 64'd0, "R1 start_req");
      rd(A_CTRL,  32'h0, "R1 ctrl");
      rd(A_ESTAT, 32'h0, "R1 estat");
      rd(A_INP_H, 32'h0, "R1 inp_h");
      rd(A_DNE_L, 32'h0, "R1 done_l");
      // R11 control word
      wr(A_CTRL, 32'hFFFF_FFFF);
      rd(A_CTRL, 32'h8000_000C, "R11 ctrl mask");
      chk({61'd0, dyn_clk_en, rr_group, rr_chan}, 64'd7, "R11 exported");
      wr(A_CTRL, 32'h0000_0004);
      chk({61'd0, dyn_clk_en, rr_group, rr_chan}, 64'd1, "R11 rr_chan only");
      // R2 request enable
      wr(A_C_SRQ, 32'd5);
      wr(A_C_SRQ, 32'd40);
      chk(req_en, (64'd1 << 5) | (64'd1 << 40), "R2 req_en set");
      rd(A_RQE_L, 32'h20, "R2 low word");
      rd(A_RQE_H, 32'h100, "R2 high word");
      wr(A_C_CRQ, 32'd5);
      chk(req_en, 64'd1 << 40, "R2 req_en clear one");
      // R5 out-of-range commands
      wr(A_C_SRQ, 32'h40);
      wr(A_C_SRQ, 32'h85);
      wr(A_C_CRQ, 32'h68);
      chk(req_en, 64'd1 << 40, "R5 req_en untouched");
      wr(A_C_STA, 32'h47);
      chk(start_req, 64'd0, "R5 no start pulse");
      // R4 start pulse
      wr(A_C_STA, 32'd33);
      chk(start_req, 64'd1 << 33, "R4 start pulse");
      @(negedge clk);
      chk(start_req, 64'd0, "R4 pulse one cycle");
      // R6 / R12 completion
      done_ev(6'd2);
      chk({63'd0, irq}, 64'd1, "R12 irq on pending");
      rd(A_INP_L, 32'h4, "R6 inp set");
      rd(A_DNE_L, 32'h4, "R6 done set");
      wr(A_C_CDN, 32'd2);
      rd(A_DNE_L, 32'h0, "R6 done cleared");
      rd(A_INP_L, 32'h4, "R6 inp kept");
      wr(A_C_CIN, 32'd2);
      rd(A_INP_L, 32'h0, "R6 inp cleared");
      chk({63'd0, irq}, 64'd0, "R12 irq low");
      // R7 write-one-to-clear
      done_ev(6'd35);
      done_ev(6'd36);
      done_ev(6'd3);
      wr(A_INP_H, 32'h10);
      rd(A_INP_H, 32'h8, "R7 partial w1c");
      wr(A_INP_H, 32'hFFFF_FFFF);
      rd(A_INP_H, 32'h0, "R7 all ones high");
      rd(A_INP_L, 32'h8, "R7 low untouched");
      wr(A_INP_L, 32'hFFFF_FFFF);
      rd(A_INP_L, 32'h0, "R7 all ones low");
      // R8 / R9 / R3 / R12 error path
      err_ev(6'd10, 10'h281);
      rd(A_ERP_L, 32'h400, "R8 err pending");
      chk({63'd0, irq}, 64'd0, "R12 err masked");
      rd(A_ESTAT, 32'h8000_8A81, "R9 capture");
      wr(A_C_SEI, 32'd10);
      rd(A_EIE_L, 32'h400, "R3 eie set");
      chk({63'd0, irq}, 64'd1, "R12 err unmasked");
      // R10 first error held
      err_ev(6'd50, 10'h104);
      rd(A_ERP_H, 32'h4_0000, "R8 err high");
      rd(A_ESTAT, 32'h8000_8A81, "R10 held");
      wr(A_C_CER, 32'd50);
      rd(A_ESTAT, 32'h8000_8A81, "R10 other chan clear");
      wr(A_C_CER, 32'd10);
      rd(A_ESTAT, 32'h0, "R10 released by port");
      rd(A_ERP_L, 32'h0, "R10 pending cleared");
      chk({63'd0, irq}, 64'd0, "R12 irq after clear");
      err_ev(6'd20, 10'h010);
      rd(A_ESTAT, 32'h8000_1410, "R9 second capture");
      wr(A_ERP_L, 32'hFFFF_FFFF);
      rd(A_ESTAT, 32'h0, "R10 released by word");
      wr(A_C_CEI, 32'd10);
      rd(A_EIE_L, 32'h0, "R3 eie cleared");
      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule